// File: doc/BRIEF.md
# Linked-List Descriptor Fetch Sequencer

This block walks a chain of command descriptors kept in memory and feeds each one to a transfer engine. Software loads a head pointer and pulses the list-start input. The sequencer then reads the eight-word descriptor at that node, one word per accepted request on a simple word-read port. The words go into the channel's register image, which is presented in parallel to the engine. It then pulses the engine's start input and waits for the engine to report that the command is finished.

When the command finishes, the sequencer raises a completion event. It then takes the next-node word of the image (word 5) as the address of the next descriptor. A zero next-node word ends the chain. A non-zero word makes the sequencer fetch again, so a last node that points back to the head gives an endless circular list. One extra event marks the loading of the first descriptor of each run. A cancel input abandons the run at any point.

Top module: `list_seq`

## Requirements
- R1: A one-cycle list_en pulse while idle starts a run at head_ptr with its two low bits forced to zero. busy is high from the next cycle.
- R2: A descriptor is read as eight words at consecutive word addresses node, node+4, … node+28. Each request holds rd_req and a stable rd_addr until the cycle in which rd_ack is high.
- R3: The word accepted for offset i appears verbatim on regs_out[32*i +: 32] and stays there until the next fetch overwrites it. Word 0 is general config, 1 read-port config, 2 read address, 3 write address, 4 transfer size, 5 next node, 6 commands done and 7 control. In word 7, bit 0 is channel enable and bit 4 is list enable.
- R4: xfer_go is a one-cycle pulse in the cycle after the eighth word is accepted. There is exactly one pulse per descriptor.
- R5: seq_evt pulses for one cycle together with xfer_go of the first descriptor of a run, and for one cycle in the cycle after xfer_done. A chain of N commands therefore yields N+1 events.
- R6: After the completion event, a zero next-node word returns the sequencer to idle (busy low). A non-zero word starts a fetch at that address. No read request is made between xfer_done and its completion event.
- R7: A next-node word that points back to an earlier node is followed indefinitely, and busy never falls on its own.
- R8: cancel returns the sequencer to idle in the next cycle from any state, and drops an outstanding fetch. No xfer_go and no event follow.
- R9: list_en while a run is in progress is ignored: the current chain continues unchanged.
- R10: After reset busy, rd_req, xfer_go and seq_evt are low and regs_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| list_en | input | 1 | Start pulse, acted on only while idle |
| head_ptr | input | AW | Byte address of the first descriptor |
| cancel | input | 1 | Abandon the current run |
| rd_req | output | 1 | Word read request |
| rd_addr | output | AW | Word-aligned byte address of the request |
| rd_data | input | 32 | Read data, valid when rd_ack is high |
| rd_ack | input | 1 | Request accepted with data this cycle |
| regs_out | output | 256 | Channel register image, word i at bits 32*i+31:32*i |
| xfer_go | output | 1 | Start pulse to the transfer engine |
| xfer_done | input | 1 | Engine reports the command finished |
| seq_evt | output | 1 | Load or completion event pulse |
| busy | output | 1 | A run is in progress |

## Verification
The memory model acknowledges requests on an irregular ready pattern, so each fetch takes a varying number of cycles. The bench therefore waits for xfer_go instead of counting cycles, and checks the full register image and the load event in that cycle. The completion event is due one cycle after xfer_done, and the bench samples it at the next falling edge. The return to idle, after a zero next-node word or after cancel, is due one cycle after that, and the bench checks busy there. Event counts, start-pulse counts and the absence of read requests between xfer_done and its event are tallied at rising edges and compared after each run.

// File: rtl/list_seq.sv
module list_seq #(
  parameter int AW       = 32,
  parameter int NW       = 8,
  parameter int NEXT_IDX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             list_en,
  input  logic [AW-1:0]    head_ptr,
  input  logic             cancel,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic [31:0]      rd_data,
  input  logic             rd_ack,
  output logic [NW*32-1:0] regs_out,
  output logic             xfer_go,
  input  logic             xfer_done,
  output logic             seq_evt,
  output logic             busy
);
  localparam int IW = $clog2(NW);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_GO, S_RUN, S_DONE} state_t;

  state_t          state;
  logic [31:0]     img [NW];
  logic [AW-1:0]   node;
  logic [IW-1:0]   idx;
  logic            first;
  logic [AW-1:0]   nxt;

  assign nxt     = AW'(img[NEXT_IDX]);
  assign rd_req  = (state == S_FETCH);
  assign rd_addr = node + AW'({idx, 2'b00});
  assign xfer_go = (state == S_GO);
  assign seq_evt = (state == S_DONE) || (state == S_GO && first);
  assign busy    = (state != S_IDLE);

  for (genvar g = 0; g < NW; g++) begin : g_img
    assign regs_out[32*g +: 32] = img[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      node  <= '0;
      idx   <= '0;
      first <= 1'b0;
      for (int i = 0; i < NW; i++) img[i] <= '0;
    end else if (cancel) begin
      state <= S_IDLE;
      first <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (list_en) begin
          node  <= {head_ptr[AW-1:2], 2'b00};
          idx   <= '0;
          first <= 1'b1;
          state <= S_FETCH;
        end
        S_FETCH: if (rd_ack) begin
          img[idx] <= rd_data;
          idx      <= idx + 1'b1;
          if (idx == IW'(NW-1)) state <= S_GO;
        end
        S_GO: begin
          first <= 1'b0;
          state <= S_RUN;
        end
        S_RUN: if (xfer_done) state <= S_DONE;
        S_DONE: begin
          if (nxt == '0) begin
            state <= S_IDLE;
          end else begin
            node  <= {nxt[AW-1:2], 2'b00};
            idx   <= '0;
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !cancel) |=> (rd_req && $stable(rd_addr))); // R2
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> !xfer_go); // R4
  AST_EVT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && xfer_done && !cancel) |=> seq_evt); // R5
  AST_NO_REQ_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    seq_evt |-> !rd_req); // R6
  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!busy && !xfer_go)); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && list_en && !cancel) |=> busy); // R1
endmodule

// File: tb/list_seq_tb.sv
module list_seq_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         list_en = 1'b0;
  logic [31:0]  head_ptr = '0;
  logic         cancel = 1'b0;
  logic         rd_req;
  logic [31:0]  rd_addr;
  logic [31:0]  rd_data;
  logic         rd_ack;
  logic [255:0] regs_out;
  logic         xfer_go;
  logic         xfer_done = 1'b0;
  logic         seq_evt;
  logic         busy;

  logic [31:0]  mem [64];
  logic         rdy = 1'b0;
  logic         stall = 1'b0;
  int           cyc = 0;
  int           n_chk = 0;
  int           n_bad = 0;
  int           evt_cnt = 0;
  int           go_cnt = 0;
  int           order_bad = 0;
  int           align_bad = 0;
  logic         pend = 1'b0;
  bit           finished = 1'b0;

  // scenario table: [31:16] head, [15:8] commands to run, [0] circular
  localparam logic [31:0] SCN [5] = '{
    32'h0000_0100,
    32'h0020_0300,
    32'h0022_0300,
    32'h0080_0501,
    32'h0040_0200
  };

  always #5 clk = ~clk;

  list_seq u_dut (
    .clk(clk), .rst_n(rst_n), .list_en(list_en), .head_ptr(head_ptr),
    .cancel(cancel), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_ack(rd_ack), .regs_out(regs_out), .xfer_go(xfer_go),
    .xfer_done(xfer_done), .seq_evt(seq_evt), .busy(busy)
  );

  assign rd_data = mem[rd_addr[7:2]];
  assign rd_ack  = rd_req & rdy;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    rdy <= !stall && (cyc % 4 != 1);
  end

  always @(posedge clk) begin
    if (seq_evt) evt_cnt <= evt_cnt + 1;
    if (xfer_go) go_cnt <= go_cnt + 1;
    if (rd_req && rd_addr[1:0] != 2'b00) align_bad <= align_bad + 1;
    if (rd_req && pend) order_bad <= order_bad + 1;
    if (seq_evt) pend <= 1'b0;
    else if (xfer_done && busy) pend <= 1'b1;
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not end, actual cycles %0d expected below 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] img_of(input logic [31:0] node);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = mem[node[7:2] + 6'(i)];
    return v;
  endfunction

  task automatic wait_go(output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 300 && !seen; t++) begin
      @(negedge clk);
      if (xfer_go) seen = 1'b1;
    end
  endtask

  task automatic run_scn(input logic [31:0] head, input int n, input bit circ, input bit poke);
    int   e0, g0;
    bit   seen;
    logic [31:0] node;
    e0 = evt_cnt;
    g0 = go_cnt;
    node = {head[31:2], 2'b00};
    @(negedge clk);
    head_ptr = head;
    list_en = 1'b1;
    @(negedge clk);
    list_en = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", 256'(busy), 256'(1));
    for (int k = 0; k < n; k++) begin
      wait_go(seen);
      chk(seen, "R4 xfer_go seen", 256'(seen), 256'(1));
      chk(regs_out == img_of(node), (poke && k == 2) ? "R9 R3 image" : "R3 image", regs_out, img_of(node));
      chk(mem[node[7:2] + 6'd7][0] && mem[node[7:2] + 6'd7][4], "R3 control bits", 256'(regs_out[255:224]), 256'(32'h11));
      chk(seq_evt == (k == 0), "R5 load event", 256'(seq_evt), 256'(k == 0));
      if (poke && k == 1) begin
        head_ptr = 32'h80;
        list_en = 1'b1;
        @(negedge clk);
        list_en = 1'b0;
      end
      repeat (3) @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      chk(seq_evt == 1'b1, "R5 completion event", 256'(seq_evt), 256'(1));
      node = mem[node[7:2] + 6'd5];
    end
    @(negedge clk);
    if (!circ) begin
      chk(busy == 1'b0, "R6 idle after zero next", 256'(busy), 256'(0));
    end else begin
      chk(busy == 1'b1, "R7 circular stays busy", 256'(busy), 256'(1));
      cancel = 1'b1;
      @(negedge clk);
      cancel = 1'b0;
      chk(busy == 1'b0, "R8 cancel from circular", 256'(busy), 256'(0));
    end
    repeat (2) @(negedge clk);
    chk(evt_cnt - e0 == n + 1, "R5 event count", 256'(evt_cnt - e0), 256'(n + 1));
    chk(go_cnt - g0 == n, "R4 go count", 256'(go_cnt - g0), 256'(n));
  endtask

  initial begin
    int e0, g0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < 8; i++) mem[b*8 + i] = 32'hD000_0000 | (b << 8) | i;
      mem[b*8 + 7] = 32'h0000_0011 | (b << 12);
    end
    mem[0*8 + 5] = 32'h00;
    mem[1*8 + 5] = 32'h40;
    mem[2*8 + 5] = 32'h60;
    mem[3*8 + 5] = 32'h00;
    mem[4*8 + 5] = 32'hA0;
    mem[5*8 + 5] = 32'h80;

    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !xfer_go && !seq_evt, "R10 reset outputs", 256'({busy, rd_req, xfer_go, seq_evt}), 256'(0));
    chk(regs_out == '0, "R10 reset image", regs_out, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 5; s++)
      run_scn({16'h0, SCN[s][31:16]}, int'(SCN[s][15:8]), SCN[s][0], s == 1);

    chk(order_bad == 0, "R6 no fetch before completion event", 256'(order_bad), 256'(0));
    chk(align_bad == 0, "R2 word aligned requests", 256'(align_bad), 256'(0));

    e0 = evt_cnt;
    g0 = go_cnt;
    stall = 1'b1;
    @(negedge clk);
    head_ptr = 32'h20;
    list_en = 1'b1;
    @(negedge clk);
    list_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(rd_req && rd_addr == 32'h20, "R2 request held while stalled", 256'({rd_req, rd_addr}), 256'({1'b1, 32'h20}));
    cancel = 1'b1;
    @(negedge clk);
    cancel = 1'b0;
    chk(!busy && !rd_req, "R8 cancel during fetch", 256'({busy, rd_req}), 256'(0));
    stall = 1'b0;
    repeat (20) @(negedge clk);
    chk(go_cnt == g0 && evt_cnt == e0, "R8 nothing after cancel", 256'({go_cnt - g0, evt_cnt - e0}), 256'(0));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule